// File: doc/BRIEF.md
# Read-Only I2C Conversion Result Target

This block is an I2C target that answers at one fixed 7-bit address and only supports reads. A converter-side interface hands it signed raw results with a one-cycle valid strobe. The block clamps each result into the unsigned 16-bit range and keeps the newest one. A controller that addresses the block for reading receives that value as two bytes.

SCL and SDA enter as plain inputs and pass through two-flop synchronizers. Bus edges are detected on the system clock, which must run at least 20 times faster than the bus bit rate. The block never drives SDA high. Its single output is a pull-low enable for an open-drain pad, and it changes that enable only while SCL is low. START, repeated START and STOP are recognised at any time.

Top module: `i2c_result_target`

## Requirements
- R1: After reset, `sda_pull` is 0, so SDA is released.
- R2: An address byte equal to 0010100 followed by R/W=1 is acknowledged. Address bits are sent MSB first, and the block holds `sda_pull`=1 through the ninth clock. This works with SCL half-periods of 20 and 60 system clocks.
- R3: Any other address is not acknowledged. SDA stays released for the rest of that transfer, until the next START.
- R4: The correct address with R/W=0 (write) is not acknowledged.
- R5: After the address acknowledge, the block sends the high byte and then the low byte of the result, MSB first. `sda_pull`=1 encodes a 0 bit.
- R6: A raw result below 0 is reported as 0, and one above 65535 is reported as 65535. Values from 0 to 65535 are reported unchanged.
- R7: Each `raw_valid` pulse replaces the held result, so the newest one wins. The held result is 0 before any pulse arrives.
- R8: The held result is copied at the address acknowledge. Results that arrive later do not change the bytes of the transfer in progress.
- R9: When the controller acknowledges a byte, the next byte follows. After the low byte, the high byte is sent again.
- R10: When the controller does not acknowledge a byte, SDA is released until the next START or STOP.
- R11: A repeated START with no STOP before it begins a new address phase, the same as a START.
- R12: `sda_pull` changes only while SCL is low. The only exceptions are a START or STOP, which release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| raw_result | input | RAW_W | Signed raw conversion result |
| raw_valid | input | 1 | One-cycle strobe marking `raw_result` as new |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest case is a result update that lands between the two bytes of one read. The snapshot must hold the high byte and the low byte to the same conversion even while the live register has moved on. The bench drives the bus one bit at a time and pushes a new result at that exact point. It then reads the bytes and afterwards starts a fresh read to confirm the newer value did get held. A repeated START issued right after a controller NACK, with no STOP in between, is reached the same way. Random results spanning the whole signed raw range, read at two bus speeds, cover the clamp limits.

// File: rtl/i2c_result_target.sv
module i2c_result_target #(
  parameter logic [6:0] DEV_ADDR = 7'b0010100,
  parameter int RAW_W = 18,
  parameter int RES_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  input  logic signed [RAW_W-1:0] raw_result,
  input  logic                    raw_valid,
  output logic                    sda_pull
);
  localparam int BYTE_BITS = 8;
  localparam int CW = $clog2(BYTE_BITS + 1);
  localparam logic signed [RAW_W-1:0] MAX_RAW = RAW_W'((1 << RES_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AWAIT, S_ADRV, S_TX, S_MACK, S_MRDY} st_t;

  st_t            state;
  logic [2:0]     scl_p, sda_p;
  logic [CW-1:0]  cnt;
  logic [6:0]     rx;
  logic [RES_W-1:0] held, tx, clamped;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire bus_start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire bus_stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  assign clamped = raw_result[RAW_W-1] ? '0 :
                   (raw_result > MAX_RAW) ? '1 : raw_result[RES_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      held  <= '0;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
      if (raw_valid) held <= clamped;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
      sda_pull <= 1'b0;
    end else if (bus_start) begin
      state    <= S_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_ADDR:
          if (scl_rise) begin
            if (cnt == CW'(BYTE_BITS - 1)) begin
              if (rx == DEV_ADDR && sda_p[1]) begin
                state <= S_AWAIT;
                tx    <= held;
              end else state <= S_IDLE;
            end else begin
              rx  <= {rx[5:0], sda_p[1]};
              cnt <= cnt + 1'b1;
            end
          end
        S_AWAIT:
          if (scl_fall) begin
            sda_pull <= 1'b1;
            state    <= S_ADRV;
          end
        S_ADRV, S_MRDY:
          if (scl_fall) begin
            sda_pull <= ~tx[RES_W-1];
            cnt      <= '0;
            state    <= S_TX;
          end
        S_TX: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          if (scl_fall) begin
            tx <= {tx[RES_W-2:0], tx[RES_W-1]};
            if (cnt == CW'(BYTE_BITS)) begin
              sda_pull <= 1'b0;
              state    <= S_MACK;
            end else sda_pull <= ~tx[RES_W-2];
          end
        end
        S_MACK:
          if (scl_rise) state <= sda_p[1] ? S_IDLE : S_MRDY;
        default: state <= S_IDLE;
      endcase
    end

  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_p[1]); // R12
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_pull); // R10
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid && raw_result[RAW_W-1] |=> held == '0); // R6
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid && !raw_result[RAW_W-1] && raw_result > MAX_RAW |=> held == '1); // R6
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state inside {S_TX, S_MACK, S_MRDY} && $past(state) inside {S_TX, S_MACK, S_MRDY}
      && !$past(scl_fall) |-> $stable(tx)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BYTE_BITS)); // R9
endmodule

// File: tb/i2c_result_target_tb.sv
module i2c_result_target_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic signed [17:0] raw = '0;
  logic raw_valid = 1'b0;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0, half = 20, viol = 0;
  logic scl_q = 1'b1, pull_q = 1'b0;
  logic [15:0] exp_res = '0;

  i2c_result_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .raw_result(raw), .raw_valid(raw_valid), .sda_pull(sda_pull));

  always @(negedge clk) begin
    if (rst_n && scl_m && scl_q && sda_pull !== pull_q) viol++;
    scl_q  <= scl_m;
    pull_q <= sda_pull;
  end

  function automatic logic [15:0] clamp16(int v);
    if (v < 0) return 16'h0000;
    if (v > 65535) return 16'hFFFF;
    return v[15:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int v);
    @(negedge clk);
    raw = 18'(v);
    raw_valid = 1'b1;
    @(negedge clk);
    raw_valid = 1'b0;
    exp_res = clamp16(v);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wt(half);
    scl_m = 1'b1; wt(half);
    sda_m = 1'b0; wt(half);
    scl_m = 1'b0; wt(half);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wt(half);
    scl_m = 1'b1; wt(half);
    sda_m = 1'b1; wt(half);
  endtask

  task automatic wbit(bit b);
    sda_m = b; wt(half);
    scl_m = 1'b1; wt(half);
    scl_m = 1'b0;
  endtask

  task automatic rbit(output bit b);
    sda_m = 1'b1; wt(half);
    scl_m = 1'b1; wt(half / 2);
    b = sda_line; wt(half - half / 2);
    scl_m = 1'b0;
  endtask

  task automatic addr(input logic [6:0] a, input bit rw, output bit ack);
    for (int i = 6; i >= 0; i--) wbit(a[i]);
    wbit(rw);
    rbit(ack);
  endtask

  task automatic rbyte(output logic [7:0] v, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(nack);
  endtask

  task automatic read2(input string req, input int h);
    bit ack;
    logic [7:0] hi, lo;
    half = h;
    bstart();
    addr(7'b0010100, 1'b1, ack);
    chk(ack == 1'b0, "R2", ack, 0);
    rbyte(hi, 1'b0);
    rbyte(lo, 1'b1);
    chk({hi, lo} == exp_res, req, {hi, lo}, exp_res);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b0, b1, b2;
    int v;
    void'($urandom(1234));
    wt(10);
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);
    rst_n = 1'b1;
    wt(10);
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);

    // R7 zero before any result, R10 release after NACK
    bstart();
    addr(7'b0010100, 1'b1, ack);
    chk(ack == 1'b0, "R2", ack, 0);
    rbyte(b0, 1'b0);
    rbyte(b1, 1'b1);
    chk({b0, b1} == 16'h0000, "R7", {b0, b1}, 0);
    wt(5);
    chk(sda_pull == 1'b0, "R10", sda_pull, 0);
    rbyte(b2, 1'b1);
    chk(b2 == 8'hFF, "R10", b2, 8'hFF);
    bstop();

    push(16'h1234);
    read2("R5", 20);
    push(-5);
    read2("R6", 20);
    push(70000);
    read2("R6", 60);
    push(65535);
    read2("R6", 20);

    // R3 wrong address
    bstart();
    addr(7'b0010101, 1'b1, ack);
    chk(ack == 1'b1, "R3", ack, 1);
    rbyte(b0, 1'b0);
    chk(b0 == 8'hFF, "R3", b0, 8'hFF);
    bstop();

    // R4 write direction
    bstart();
    addr(7'b0010100, 1'b0, ack);
    chk(ack == 1'b1, "R4", ack, 1);
    bstop();

    // R7 last wins
    push(100);
    push(16'hBEEF);
    read2("R7", 20);

    // R8 snapshot across mid-transfer update
    push(16'hA55A);
    bstart();
    addr(7'b0010100, 1'b1, ack);
    rbyte(b0, 1'b0);
    push(16'h0FF0);
    rbyte(b1, 1'b1);
    chk({b0, b1} == 16'hA55A, "R8", {b0, b1}, 16'hA55A);
    bstop();
    read2("R8", 20);

    // R9 third byte repeats high byte
    push(16'hC3E1);
    bstart();
    addr(7'b0010100, 1'b1, ack);
    rbyte(b0, 1'b0);
    rbyte(b1, 1'b0);
    rbyte(b2, 1'b1);
    chk({b0, b1} == 16'hC3E1, "R9", {b0, b1}, 16'hC3E1);
    chk(b2 == 8'hC3, "R9", b2, 8'hC3);

    // R11 repeated start without stop
    push(16'h7E81);
    bstart();
    addr(7'b0010100, 1'b1, ack);
    chk(ack == 1'b0, "R11", ack, 0);
    rbyte(b0, 1'b0);
    rbyte(b1, 1'b1);
    chk({b0, b1} == 16'h7E81, "R11", {b0, b1}, 16'h7E81);
    bstop();

    for (int k = 0; k < 14; k++) begin
      v = int'($urandom_range(0, 262143)) - 131072;
      push(v);
      read2("R6", ($urandom_range(0, 1) != 0) ? 60 : 20);
    end

    chk(viol == 0, "R12", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule